// File: doc/BRIEF.md
# Immediate, Upper-Value and Branch Target Generator

This block sits in the decode stage of a 32-bit RISC pipeline whose instructions are all one word long and start on 4-byte boundaries. It reads the current program counter and the fetched instruction word. It sorts the word into one of three format groups: call, the upper-immediate/branch group, or the arithmetic/memory group. From that it produces every operand that the decoder derives from the word itself. These are the sign-extended short immediate, the upper-immediate value with its low bits cleared, and the PC-relative target of a call or a conditional branch. For branches it also passes on the annul bit and the condition nibble.

The block also checks the destination register of double-word memory accesses. Such an access uses a register pair, so the first register must be even. An odd first register is flagged. Sub-opcodes that the upper-immediate/branch group does not use raise an illegal-format flag. Every output is combinational from the two inputs. The register file, condition evaluation and delay-slot sequencing belong to other blocks.

Top module: `imm_branch_gen`

## Requirements
- R1: The top two instruction bits select the format. 01 is call and raises isCall. 00 is the upper-immediate/branch group. 10 and 11 raise isAluMem.
- R2: For a call, targetValid is 1 and targetAddr = pcIn + {instrIn[29:0], 2'b00}, taken modulo 2^32.
- R3: A branch has top bits 00 and sub-opcode bits 24:22 equal to 010 or 110, and raises isBranch. Its targetAddr = pcIn + (sign-extended instrIn[21:0] shifted left by 2), taken modulo 2^32, and targetValid is 1.
- R4: An upper-immediate instruction has top bits 00 and sub-opcode 100, and raises isSethi. Its sethiVal = {instrIn[21:0], 10'b0}.
- R5: In formats 10 and 11 with instrIn[13] = 1, immValid is 1 and immOut is instrIn[12:0] sign-extended to 32 bits. With instrIn[13] = 0, immValid and immOut are 0.
- R6: For a branch, annulBit = instrIn[29] and condCode = instrIn[28:25]. For every other format both are 0.
- R7: oddPair is 1 only when all of the following hold: the top bits are 11, the operation field instrIn[24:19] has bit 3 = 0 and bits 1:0 = 11 (a double-word load or store), and the destination register instrIn[29:25] is odd.
- R8: Top bits 00 with sub-opcode 000, 001, 011, 101 or 111 raise illegalFmt.
- R9: targetAddr and targetValid are 0 unless the word is a call or a branch. sethiVal is 0 unless the word is upper-immediate. immOut is 0 outside formats 10 and 11.
- R10: Exactly one of isCall, isSethi, isBranch, isAluMem and illegalFmt is 1 for every instruction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pcIn | input | 32 | Address of the instruction being decoded |
| instrIn | input | 32 | Instruction word |
| isCall | output | 1 | Word is a call |
| isSethi | output | 1 | Word is an upper-immediate load |
| isBranch | output | 1 | Word is a conditional branch |
| isAluMem | output | 1 | Word is arithmetic or memory format |
| illegalFmt | output | 1 | Unused sub-opcode in the upper-immediate/branch group |
| targetValid | output | 1 | targetAddr carries a call or branch target |
| targetAddr | output | 32 | PC-relative target address |
| sethiVal | output | 32 | Upper immediate with low 10 bits cleared |
| immValid | output | 1 | immOut carries an extended immediate |
| immOut | output | 32 | Sign-extended 13-bit immediate |
| annulBit | output | 1 | Branch annul bit |
| condCode | output | 4 | Branch condition field |
| oddPair | output | 1 | Double-word access names an odd first register |

## Verification
The bench builds the block twice with the default 32-bit word, 22-bit displacement and 13-bit immediate. One instance uses the shared target adder (SHARED_ADDER=1) and one uses a separate adder per format (SHARED_ADDER=0). Both must give the same target for every stimulus, so both generate variants are exercised. The default widths bring the true edges within reach: the largest positive and negative call and branch displacements, wrap-around of the target past address zero, the sign bit of the 13-bit immediate, and every sub-opcode of the upper-immediate/branch group.

// File: rtl/rbtg_pkg.sv
`timescale 1ns/1ps
package rbtg_pkg;

  typedef enum logic [1:0] {
    FMT_UPPER = 2'b00,
    FMT_CALL  = 2'b01,
    FMT_ALU   = 2'b10,
    FMT_MEM   = 2'b11
  } fmtE;

  localparam logic [2:0] SUB_SETHI = 3'b100;
  localparam logic [2:0] SUB_BR_INT = 3'b010;
  localparam logic [2:0] SUB_BR_FLT = 3'b110;

  // strobes from control to datapath
  typedef struct packed {
    logic selCall;
    logic selBranch;
    logic selSethi;
    logic selImm;
  } strobeT;

endpackage

// File: rtl/rbtg_ctrl.sv
`timescale 1ns/1ps
module rbtg_ctrl
  import rbtg_pkg::*;
(
  input  logic [1:0] opIn,
  input  logic [2:0] subOpIn,
  input  logic [5:0] op3In,
  input  logic       rdLsbIn,
  input  logic       immSelIn,
  output strobeT     stb,
  output logic       isCall,
  output logic       isSethi,
  output logic       isBranch,
  output logic       isAluMem,
  output logic       illegalFmt,
  output logic       targetValid,
  output logic       immValid,
  output logic       oddPair
);

  logic dwordAccess;

  always_comb begin
    isCall     = 1'b0;
    isSethi    = 1'b0;
    isBranch   = 1'b0;
    isAluMem   = 1'b0;
    illegalFmt = 1'b0;
    unique case (fmtE'(opIn))
      FMT_CALL:  isCall = 1'b1;
      FMT_UPPER: begin
        unique case (subOpIn)
          SUB_SETHI:               isSethi    = 1'b1;
          SUB_BR_INT, SUB_BR_FLT:  isBranch   = 1'b1;
          default:                 illegalFmt = 1'b1;
        endcase
      end
      default:   isAluMem = 1'b1;
    endcase
  end

  // double-word load/store: op3 bit 3 clear, bits 1:0 both set
  assign dwordAccess = (fmtE'(opIn) == FMT_MEM) && !op3In[3] && (op3In[1:0] == 2'b11);
  assign oddPair     = dwordAccess && rdLsbIn;
  assign immValid    = isAluMem && immSelIn;
  assign targetValid = isCall || isBranch;

  assign stb.selCall   = isCall;
  assign stb.selBranch = isBranch;
  assign stb.selSethi  = isSethi;
  assign stb.selImm    = immValid;

  always_comb begin
    a_r10_one_format: assert ($countones({isCall, isSethi, isBranch, isAluMem, illegalFmt}) == 1)
      else $error("R10: format flags not one-hot");
    a_r7_pair_mem_only: assert (!oddPair || (opIn == 2'b11 && rdLsbIn))
      else $error("R7: odd pair flagged outside memory format");
    a_r5_imm_group: assert (!immValid || opIn[1])
      else $error("R5: immediate valid outside arithmetic/memory");
  end

endmodule

// File: rtl/rbtg_datapath.sv
`timescale 1ns/1ps
module rbtg_datapath
  import rbtg_pkg::*;
#(
  parameter int DW           = 32,
  parameter int DISP_W       = 22,
  parameter int SIMM_W       = 13,
  parameter bit SHARED_ADDER = 1'b1
) (
  input  logic [DW-1:0] pcIn,
  input  logic [DW-3:0] fieldIn,
  input  strobeT        stb,
  output logic [DW-1:0] targetAddr,
  output logic [DW-1:0] sethiVal,
  output logic [DW-1:0] immOut,
  output logic          annulBit,
  output logic [3:0]    condCode
);

  localparam int LOW_W   = DW - DISP_W;
  localparam int BR_EXT  = DW - DISP_W - 2;
  localparam int IMM_EXT = DW - SIMM_W;
  localparam int ANNUL_B = DW - 3;

  logic [DW-1:0] callOff;
  logic [DW-1:0] brOff;

  assign callOff = {fieldIn, 2'b00};
  assign brOff   = {{BR_EXT{fieldIn[DISP_W-1]}}, fieldIn[DISP_W-1:0], 2'b00};

  generate
    if (SHARED_ADDER) begin : g_shared
      logic [DW-1:0] offSel;
      logic [DW-1:0] sum;
      assign offSel = stb.selCall ? callOff : brOff;
      assign sum    = pcIn + offSel;
      assign targetAddr = (stb.selCall || stb.selBranch) ? sum : '0;
    end else begin : g_split
      logic [DW-1:0] callSum;
      logic [DW-1:0] brSum;
      assign callSum = pcIn + callOff;
      assign brSum   = pcIn + brOff;
      always_comb begin
        targetAddr = '0;
        if (stb.selCall)        targetAddr = callSum;
        else if (stb.selBranch) targetAddr = brSum;
      end
    end
  endgenerate

  assign sethiVal = stb.selSethi ? {fieldIn[DISP_W-1:0], {LOW_W{1'b0}}} : '0;
  assign immOut   = stb.selImm ? {{IMM_EXT{fieldIn[SIMM_W-1]}}, fieldIn[SIMM_W-1:0]} : '0;
  assign annulBit = stb.selBranch ? fieldIn[ANNUL_B] : 1'b0;
  assign condCode = stb.selBranch ? fieldIn[ANNUL_B-1:ANNUL_B-4] : 4'd0;

  always_comb begin
    a_r4_low_clear: assert (sethiVal[LOW_W-1:0] == '0)
      else $error("R4: upper value low bits not clear");
    a_r5_sign_fill: assert (!stb.selImm || (immOut[DW-1:SIMM_W-1] == '0) || (&immOut[DW-1:SIMM_W-1]))
      else $error("R5: immediate not sign filled");
    a_r9_target_quiet: assert (stb.selCall || stb.selBranch || targetAddr == '0)
      else $error("R9: target driven for non-transfer word");
    a_r2_target_aligned: assert (pcIn[1:0] != 2'b00 || targetAddr[1:0] == 2'b00)
      else $error("R2: target lost word alignment");
    a_r6_cond_quiet: assert (stb.selBranch || (condCode == 4'd0 && !annulBit))
      else $error("R6: branch fields driven outside branch");
  end

endmodule

// File: rtl/imm_branch_gen.sv
`timescale 1ns/1ps
module imm_branch_gen
  import rbtg_pkg::*;
#(
  parameter int DW           = 32,
  parameter int DISP_W       = 22,
  parameter int SIMM_W       = 13,
  parameter bit SHARED_ADDER = 1'b1
) (
  input  logic [DW-1:0] pcIn,
  input  logic [DW-1:0] instrIn,
  output logic          isCall,
  output logic          isSethi,
  output logic          isBranch,
  output logic          isAluMem,
  output logic          illegalFmt,
  output logic          targetValid,
  output logic [DW-1:0] targetAddr,
  output logic [DW-1:0] sethiVal,
  output logic          immValid,
  output logic [DW-1:0] immOut,
  output logic          annulBit,
  output logic [3:0]    condCode,
  output logic          oddPair
);

  localparam int OP_LO  = DW - 2;
  localparam int SUB_HI = DISP_W + 2;
  localparam int OP3_LO = DISP_W - 3;
  localparam int RD_LSB = DW - 7;

  strobeT stb;

  rbtg_ctrl u_ctrl (
    .opIn       (instrIn[DW-1:OP_LO]),
    .subOpIn    (instrIn[SUB_HI:DISP_W]),
    .op3In      (instrIn[SUB_HI:OP3_LO]),
    .rdLsbIn    (instrIn[RD_LSB]),
    .immSelIn   (instrIn[SIMM_W]),
    .stb        (stb),
    .isCall     (isCall),
    .isSethi    (isSethi),
    .isBranch   (isBranch),
    .isAluMem   (isAluMem),
    .illegalFmt (illegalFmt),
    .targetValid(targetValid),
    .immValid   (immValid),
    .oddPair    (oddPair)
  );

  rbtg_datapath #(
    .DW          (DW),
    .DISP_W      (DISP_W),
    .SIMM_W      (SIMM_W),
    .SHARED_ADDER(SHARED_ADDER)
  ) u_dp (
    .pcIn      (pcIn),
    .fieldIn   (instrIn[OP_LO-1:0]),
    .stb       (stb),
    .targetAddr(targetAddr),
    .sethiVal  (sethiVal),
    .immOut    (immOut),
    .annulBit  (annulBit),
    .condCode  (condCode)
  );

endmodule

// File: tb/imm_branch_gen_bench.sv
`timescale 1ns/1ps
module imm_branch_gen_bench;

  typedef struct packed {
    logic        isCall, isSethi, isBranch, isAluMem, illegalFmt;
    logic        targetValid;
    logic [31:0] targetAddr;
    logic [31:0] sethiVal;
    logic        immValid;
    logic [31:0] immOut;
    logic        annulBit;
    logic [3:0]  condCode;
    logic        oddPair;
  } expT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] pcIn = '0, instrIn = '0;
  expT  got;
  logic [31:0] splitTarget;
  int checks = 0, failures = 0;
  expT expQ[$];
  logic [63:0] stimQ[$];

  imm_branch_gen u_imm_branch_gen (
    .pcIn(pcIn), .instrIn(instrIn),
    .isCall(got.isCall), .isSethi(got.isSethi), .isBranch(got.isBranch),
    .isAluMem(got.isAluMem), .illegalFmt(got.illegalFmt),
    .targetValid(got.targetValid), .targetAddr(got.targetAddr),
    .sethiVal(got.sethiVal), .immValid(got.immValid), .immOut(got.immOut),
    .annulBit(got.annulBit), .condCode(got.condCode), .oddPair(got.oddPair)
  );

  logic sIsCall, sIsSethi, sIsBranch, sIsAluMem, sIll, sTv, sImmV, sAnnul, sOdd;
  logic [31:0] sSethi, sImm;
  logic [3:0]  sCond;

  imm_branch_gen #(.SHARED_ADDER(1'b0)) u_imm_branch_gen_split (
    .pcIn(pcIn), .instrIn(instrIn),
    .isCall(sIsCall), .isSethi(sIsSethi), .isBranch(sIsBranch),
    .isAluMem(sIsAluMem), .illegalFmt(sIll),
    .targetValid(sTv), .targetAddr(splitTarget),
    .sethiVal(sSethi), .immValid(sImmV), .immOut(sImm),
    .annulBit(sAnnul), .condCode(sCond), .oddPair(sOdd)
  );

  function automatic expT model(input logic [31:0] pc, input logic [31:0] ins);
    expT e = '0;
    logic signed [31:0] d;
    case (ins[31:30])
      2'b01: begin
        e.isCall = 1; e.targetValid = 1;
        e.targetAddr = pc + (ins << 2);
      end
      2'b00: begin
        if (ins[24:22] == 3'b100) begin
          e.isSethi = 1; e.sethiVal = ins << 10;
        end else if (ins[24:22] == 3'b010 || ins[24:22] == 3'b110) begin
          e.isBranch = 1; e.targetValid = 1;
          d = {{10{ins[21]}}, ins[21:0]};
          e.targetAddr = pc + 32'(d * 4);
          e.annulBit = ins[29]; e.condCode = ins[28:25];
        end else e.illegalFmt = 1;
      end
      default: begin
        e.isAluMem = 1;
        if (ins[13]) begin
          e.immValid = 1;
          d = {{19{ins[12]}}, ins[12:0]};
          e.immOut = d;
        end
        if (ins[31:30] == 2'b11 && ins[22] == 1'b0 && ins[20:19] == 2'b11 && ins[25])
          e.oddPair = 1;
      end
    endcase
    return e;
  endfunction

  function automatic logic [31:0] mkCall(input logic [29:0] disp);
    return {2'b01, disp};
  endfunction
  function automatic logic [31:0] mkUp(input logic a, input logic [3:0] c,
                                       input logic [2:0] sub, input logic [21:0] v);
    return {2'b00, a, c, sub, v};
  endfunction
  function automatic logic [31:0] mkF3(input logic [1:0] op, input logic [4:0] rd,
                                       input logic [5:0] op3, input logic i,
                                       input logic [12:0] low);
    return {op, rd, op3, 5'd3, i, low};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] pc, input logic [31:0] ins);
    @(posedge clk);
    #1;
    pcIn = pc; instrIn = ins;
    expQ.push_back(model(pc, ins));
    stimQ.push_back({pc, ins});
  endtask

  // monitor: compare every produced result against the scoreboard queue
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expT e;
      logic [63:0] s;
      e = expQ.pop_front();
      s = stimQ.pop_front();
      chk(got.isCall == e.isCall && got.isAluMem == e.isAluMem, "R1 format", {got.isCall, got.isAluMem}, {e.isCall, e.isAluMem});
      chk(got.isBranch == e.isBranch, "R3 isBranch", got.isBranch, e.isBranch);
      chk(got.isSethi == e.isSethi, "R4 isSethi", got.isSethi, e.isSethi);
      chk(got.illegalFmt == e.illegalFmt, "R8 illegalFmt", got.illegalFmt, e.illegalFmt);
      chk($countones({got.isCall, got.isSethi, got.isBranch, got.isAluMem, got.illegalFmt}) == 1,
          "R10 one format", {got.isCall, got.isSethi, got.isBranch, got.isAluMem, got.illegalFmt}, 32'd1);
      if (e.isCall) chk(got.targetAddr == e.targetAddr, "R2 call target", got.targetAddr, e.targetAddr);
      if (e.isBranch) chk(got.targetAddr == e.targetAddr, "R3 branch target", got.targetAddr, e.targetAddr);
      chk(got.targetValid == e.targetValid && (e.targetValid || got.targetAddr == 0),
          "R9 target quiet", got.targetAddr, e.targetAddr);
      chk(splitTarget == e.targetAddr, "R2 R3 split adder target", splitTarget, e.targetAddr);
      chk(got.sethiVal == e.sethiVal, "R4 R9 sethiVal", got.sethiVal, e.sethiVal);
      chk(got.immValid == e.immValid && got.immOut == e.immOut, "R5 immOut", got.immOut, e.immOut);
      chk(got.annulBit == e.annulBit && got.condCode == e.condCode, "R6 annul/cond",
          {got.annulBit, got.condCode}, {e.annulBit, e.condCode});
      chk(got.oddPair == e.oddPair, "R7 oddPair", got.oddPair, e.oddPair);
      if (got !== e) $display("  stimulus pc=%h instr=%h", s[63:32], s[31:0]);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state: all-zero word is the unused sub-opcode 000
    chk(got.illegalFmt == 1'b1 && got.targetValid == 1'b0, "R8 reset state", got.illegalFmt, 1);
    // R2 call: small, maximum positive, negative, wrap
    drive(32'h0000_1000, mkCall(30'd4));
    drive(32'h0000_0000, mkCall(30'h1FFF_FFFF));
    drive(32'h8000_0000, mkCall(30'h3FFF_FFFF));
    drive(32'hFFFF_FFF0, mkCall(30'd8));
    // R3 R6 branches: positive, most negative, wrap below zero, float branch
    drive(32'h0040_0000, mkUp(1'b1, 4'hA, 3'b010, 22'd16));
    drive(32'h0400_0000, mkUp(1'b0, 4'h5, 3'b010, 22'h20_0000));
    drive(32'h0000_0008, mkUp(1'b1, 4'hF, 3'b110, 22'h3F_FFFC));
    drive(32'h1234_5678, mkUp(1'b0, 4'h1, 3'b110, 22'h1F_FFFF));
    // R4 upper immediate, with annul/cond bits set to show they are ignored
    drive(32'h0, mkUp(1'b1, 4'hF, 3'b100, 22'h3F_FFFF));
    drive(32'h0, mkUp(1'b0, 4'h0, 3'b100, 22'h00_0001));
    // R8 every unused sub-opcode
    drive(32'h100, mkUp(1'b1, 4'h7, 3'b000, 22'h12345));
    drive(32'h100, mkUp(1'b1, 4'h7, 3'b001, 22'h12345));
    drive(32'h100, mkUp(1'b1, 4'h7, 3'b011, 22'h12345));
    drive(32'h100, mkUp(1'b1, 4'h7, 3'b101, 22'h12345));
    drive(32'h100, mkUp(1'b1, 4'h7, 3'b111, 22'h12345));
    // R5 immediates
    drive(32'h0, mkF3(2'b10, 5'd4, 6'h00, 1'b1, 13'h0FFF));
    drive(32'h0, mkF3(2'b10, 5'd4, 6'h00, 1'b1, 13'h1000));
    drive(32'h0, mkF3(2'b10, 5'd4, 6'h00, 1'b0, 13'h1FFF));
    drive(32'h0, mkF3(2'b11, 5'd2, 6'h00, 1'b1, 13'h1FFE));
    // R7 pairs
    drive(32'h0, mkF3(2'b11, 5'd3, 6'b000011, 1'b0, 13'd0));
    drive(32'h0, mkF3(2'b11, 5'd4, 6'b000011, 1'b0, 13'd0));
    drive(32'h0, mkF3(2'b11, 5'd7, 6'b000111, 1'b1, 13'd5));
    drive(32'h0, mkF3(2'b11, 5'd9, 6'b010111, 1'b0, 13'd0));
    drive(32'h0, mkF3(2'b11, 5'd5, 6'b001111, 1'b0, 13'd0));
    drive(32'h0, mkF3(2'b11, 5'd5, 6'b000001, 1'b0, 13'd0));
    drive(32'h0, mkF3(2'b10, 5'd5, 6'b000011, 1'b0, 13'd0));
    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule